// File: doc/BRIEF.md
# Skip-Capable Scrambled Address Counter

This block generates the memory address for a circular delay buffer. A 16-bit up/down counter moves one location per count pulse and wraps in both directions. The counter is built as a chain of 4-bit stages. The counter bits reach the memory address lines through a fixed bit permutation. Successive counts therefore land on scattered addresses, but the sequence repeats exactly on every pass.

The skip input produces jumps in the delay. When skip rises, the block copies the current count into a hold register. The counter keeps counting while skip stays high. When skip falls, the held value is loaded back into the counter. Playback then jumps back, or forward, by the distance travelled during the pulse, in whichever direction the counter was moving.

The skip input is synchronised with two flops and edge-detected inside the block. Count pulses are treated as synchronous, one clock wide.

Top module: `skip_addr_counter`

## Requirements
- R1: While `rst_n` is low, the count and the hold register are zero. `mem_addr_o` reads 16'h0000 during reset and in the first cycle after it.
- R2: When `count_up_i` is 1 and `count_dn_i` is 0 at a rising clock edge, the count increases by one modulo 65536. Count 16'hFFFF steps to 16'h0000.
- R3: When `count_dn_i` is 1 and `count_up_i` is 0 at a rising clock edge, the count decreases by one modulo 65536. Count 16'h0000 steps to 16'hFFFF.
- R4: When both count inputs are 1, or both are 0, the count does not change.
- R5: A rising `skip_i` is seen at the third rising edge after the input goes high. At that edge, the hold register takes the count value that was present just before that edge.
- R6: While skip is high, count pulses keep moving the count exactly as in R2 and R3.
- R7: A falling `skip_i` is seen at the third rising edge after the input goes low. At that edge, the count is loaded from the hold register. The load takes priority over any count pulse in the same cycle.
- R8: Count bit i drives address bit MAP[i]. The default map is MAP[i] = (5*i + 3) mod 16. For example, count 5 gives address 16'h2008, and count 16'hFFFF gives address 16'hFFFF.
- R9: The map is a bijection. Starting from any count, 65536 consecutive up steps return the address to its starting value, and it does not return sooner.
- R10: Carry and borrow ripple through all four 4-bit stages within the same clock cycle. This covers crossings such as 16'h00FF to 16'h0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_up_i | input | 1 | Step the count forward at this edge |
| count_dn_i | input | 1 | Step the count backward at this edge |
| skip_i | input | 1 | Asynchronous skip level: capture on rise, reload on fall |
| mem_addr_o | output | 16 | Permuted memory address |

## Verification
A count pulse takes effect at the next rising edge. The permutation is combinational, so the new address is visible at the falling edge right after that rising edge. A skip level change acts at the third rising edge after it: two edges for the synchroniser and one for the edge detector. The hold capture and the reload both land on that edge.

The bench drives every input just after a falling edge. A behavioural model updates on each rising edge and is compared with `mem_addr_o` at every falling edge. Explicit checks for the skip sequences use hand-computed count values at the exact cycles where the capture and the reload must appear.

// File: rtl/skip_addr_pkg.sv
package skip_addr_pkg;

  // Next value of one counter slice. Increment wins if both are asked,
  // but the top never asks for both at once.
  function automatic logic [3:0] slice_next(input logic [3:0] cur,
                                            input logic       inc,
                                            input logic       dec);
    logic [3:0] nxt;
    nxt = cur;
    if (inc)      nxt = cur + 4'd1;
    else if (dec) nxt = cur - 4'd1;
    return nxt;
  endfunction

  // A slice passes a carry when it is stepping up from all ones.
  function automatic logic slice_carry(input logic [3:0] cur, input logic inc);
    return inc & (&cur);
  endfunction

  // A slice passes a borrow when it is stepping down from zero.
  function automatic logic slice_borrow(input logic [3:0] cur, input logic dec);
    return dec & ~(|cur);
  endfunction

endpackage

// File: rtl/skip_edge_sync.sv
module skip_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic skip_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], skip_i};
  end

  assign level_o = chain_q[SYNC_STAGES-1];
  assign rise_o  = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign fall_o  = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import skip_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic       dec_i,
  input  logic       load_i,
  input  logic [3:0] load_val_i,
  output logic [3:0] q_o,
  output logic       carry_o,
  output logic       borrow_o
);
  logic [3:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load_i) q <= load_val_i;
    else             q <= slice_next(q, inc_i, dec_i);
  end

  assign q_o      = q;
  assign carry_o  = slice_carry(q, inc_i);
  assign borrow_o = slice_borrow(q, dec_i);

  // R2 / R10: a slice asked to step up advances by one, wrapping at 15
  assert_slice_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && !load_i) |=> q == 4'($past(q) + 4'd1));

  // R3 / R10: a slice asked to step down moves back by one, wrapping at 0
  assert_slice_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !load_i) |=> q == 4'($past(q) - 4'd1));

  // R7: a load sets the slice to its share of the held value
  assert_slice_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> q == $past(load_val_i));

endmodule

// File: rtl/addr_permute.sv
module addr_permute #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W*$clog2(CNT_W)-1:0] BIT_MAP = 64'hE94F_A50B_61C7_2D83
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] addr_o
);
  localparam int IDX_W = $clog2(CNT_W);

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < CNT_W; i++) begin
      addr_o[BIT_MAP[i*IDX_W +: IDX_W]] = cnt_i[i];
    end
  end

  // R9: every address bit must be driven by exactly one count bit
  initial begin
    for (int i = 0; i < CNT_W; i++) begin
      for (int j = i + 1; j < CNT_W; j++) begin
        assert_map_bijective_R9: assert (BIT_MAP[i*IDX_W +: IDX_W] != BIT_MAP[j*IDX_W +: IDX_W])
          else $error("address bit map repeats an entry");
      end
    end
  end

endmodule

// File: rtl/skip_addr_counter.sv
module skip_addr_counter #(
  parameter int CNT_W       = 16,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [CNT_W*$clog2(CNT_W)-1:0] BIT_MAP = 64'hE94F_A50B_61C7_2D83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_up_i,
  input  logic             count_dn_i,
  input  logic             skip_i,
  output logic [CNT_W-1:0] mem_addr_o
);
  localparam int STAGES = CNT_W / NIB_W;

  // Named events, brought out for the assertions
  logic             skip_level;
  logic             rise_evt;
  logic             load_evt;
  logic             step_up;
  logic             step_dn;
  logic             wrap_up;
  logic             wrap_dn;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] hold_q;
  logic [STAGES-1:0] inc_c;
  logic [STAGES-1:0] dec_c;
  logic [STAGES-1:0] carry;
  logic [STAGES-1:0] borrow;

  skip_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .skip_i  (skip_i),
    .level_o (skip_level),
    .rise_o  (rise_evt),
    .fall_o  (load_evt)
  );

  // A reload beats counting; opposing pulses cancel
  assign step_up = count_up_i & ~count_dn_i & ~load_evt;
  assign step_dn = count_dn_i & ~count_up_i & ~load_evt;

  assign inc_c[0] = step_up;
  assign dec_c[0] = step_dn;

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_chain
      assign inc_c[k] = carry[k-1];
      assign dec_c[k] = borrow[k-1];
    end
    for (genvar k = 0; k < STAGES; k++) begin : g_slice
      cnt_slice u_slice (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (inc_c[k]),
        .dec_i      (dec_c[k]),
        .load_i     (load_evt),
        .load_val_i (hold_q[k*NIB_W +: NIB_W]),
        .q_o        (count_q[k*NIB_W +: NIB_W]),
        .carry_o    (carry[k]),
        .borrow_o   (borrow[k])
      );
    end
  endgenerate

  assign wrap_up = carry[STAGES-1];
  assign wrap_dn = borrow[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (rise_evt) hold_q <= count_q;
  end

  addr_permute #(.CNT_W(CNT_W), .BIT_MAP(BIT_MAP)) u_perm (
    .cnt_i  (count_q),
    .addr_o (mem_addr_o)
  );

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> hold_q == $past(count_q));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> count_q == $past(hold_q));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && (count_up_i == count_dn_i)) |=> $stable(count_q));

  assert_wrap_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> count_q == '0);

  assert_wrap_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_dn |=> count_q == '1);

  assert_skip_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_level && step_up) |=> count_q == CNT_W'($past(count_q) + 1'b1));

  assert_addr_weight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_addr_o) == $countones(count_q));

endmodule

// File: tb/skip_addr_counter_bench.sv
module skip_addr_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up = 1'b0;
  logic        dn = 1'b0;
  logic        skip = 1'b0;
  logic [15:0] addr;

  int    checks = 0;
  int    errors = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_req = "R2";

  // Behavioural reference state
  int m_cnt  = 0;
  int m_hold = 0;
  bit hist[3] = '{0, 0, 0};

  always #2 clk = ~clk;

  skip_addr_counter u_skip_addr_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_up_i (up),
    .count_dn_i (dn),
    .skip_i     (skip),
    .mem_addr_o (addr)
  );

  function automatic logic [15:0] bench_perm(input int c);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) if (c[i]) r[(5 * i + 3) % 16] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model: skip history is oldest-last; a level change shows after two samples
  always @(posedge clk) begin
    bit rise_seen, fall_seen;
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; hist = '{0, 0, 0};
    end else begin
      rise_seen = hist[1] && !hist[2];
      fall_seen = !hist[1] && hist[2];
      if (rise_seen) m_hold = m_cnt;
      if (fall_seen)       m_cnt = m_hold;
      else if (up && !dn)  m_cnt = (m_cnt + 1) % 65536;
      else if (dn && !up)  m_cnt = (m_cnt + 65535) % 65536;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = skip;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) check(cur_req, addr, bench_perm(m_cnt));
  end

  // Apply inputs just after a falling edge, return just after the next one
  task automatic step(input bit u, input bit d, input bit s);
    up = u; dn = d; skip = s;
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    chk_on = 0;
    rst_n = 0;
    repeat (3) step(0, 0, 0);
    check("R1", addr, 16'h0000);
    rst_n = 1;
    step(0, 0, 0);
    check("R1", addr, 16'h0000);
    chk_on = 1;
  endtask

  initial begin
    int n;
    logic [15:0] start;
    @(negedge clk); #1;
    do_reset();

    cur_req = "R3"; step(0, 1, 0); check("R3", addr, 16'hFFFF);
    cur_req = "R2"; step(1, 0, 0); check("R2", addr, 16'h0000);
    cur_req = "R4";
    repeat (3) step(1, 1, 0);
    step(0, 0, 0);
    check("R4", addr, 16'h0000);
    cur_req = "R8";
    repeat (5) step(1, 0, 0);
    check("R8", addr, 16'h2008);
    cur_req = "R10";
    repeat (300) step(1, 0, 0);
    check("R10", addr, bench_perm(305));
    repeat (600) step(0, 1, 0);
    check("R10", addr, bench_perm(65536 - 295));

    // Skip while counting up: capture 2, count on to 8, reload 2, end at 4
    do_reset();
    cur_req = "R6";
    repeat (6) step(1, 0, 1);
    check("R6", addr, bench_perm(6));
    repeat (2) step(1, 0, 0);
    check("R6", addr, bench_perm(8));
    cur_req = "R7";
    step(1, 0, 0);
    check("R7", addr, bench_perm(2));
    repeat (2) step(1, 0, 0);
    check("R5", addr, bench_perm(4));

    // Skip while counting down from 4: capture 2, reload 2, end at 0
    cur_req = "R5";
    repeat (8) step(0, 1, 1);
    repeat (5) step(0, 1, 0);
    check("R7", addr, 16'h0000);

    // One-cycle pulse: capture at third edge, reload at the fourth
    cur_req = "R7";
    step(1, 0, 1);
    repeat (5) step(1, 0, 0);
    check("R7", addr, bench_perm(4));
    repeat (3) step(0, 0, 0);

    // Full sweep: first return to the start address after exactly 65536 steps
    cur_req = "R9";
    start = addr;
    n = 0;
    do begin
      step(1, 0, 0);
      n++;
    end while (addr !== start && n < 70000);
    checks++;
    if (n != 65536) begin
      errors++;
      $display("FAIL R9 actual=%0d expected=%0d", n, 65536);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule